// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Handler Injection

This block is the control core of an in-order RV32 fetch unit. It reads instruction memory at its own program counter and pre-decodes each returned word. It then pushes one self-contained packet into an instruction FIFO. The packet holds the PC, an opcode class, the raw register indices, a sign-extended immediate, an illegal flag and an injected flag. The execute stage drains that FIFO on its own. The only link from execute back to fetch is a branch-resolved pulse that carries the next PC.

The sequencer handles several instructions itself:

- **JAL.** It computes the target and keeps fetching.
- **Conditional branch or JALR.** It stops and waits for execute to resolve the target.
- **WFI.** It idles for a bounded number of cycles.
- **Cache discard (FENCE.I).** It requests an instruction-cache flush and waits for it to finish.
- **Interrupt, ECALL or EBREAK.** It splices a fixed handler entry sequence from an internal ROM into the FIFO.
- **MRET.** It splices the matching exit sequence in the same way.

A soft reset request from the control-register side sends the PC back to the reset vector.

The FSM has the following states:

| State | Behaviour | Next state |
|---|---|---|
| S_BOOT | Entered after hardware reset. | S_ISSUE |
| S_ISSUE | An instruction boundary. A pending interrupt is taken here and starts injection. | S_INJ_RD (interrupt pending) or S_WAIT (read issued) |
| S_WAIT | Waits for the memory response. | S_PUSH on response |
| S_PUSH | Decodes the word and pushes it, or consumes it. The transition depends on the class. | See below |
| S_WFI | Idle count. | S_ISSUE on an interrupt or after WFI_MAX cycles |
| S_FLUSH | Holds the flush request. | S_ISSUE on flush completion |
| S_BRWAIT | Waits for the branch-resolved pulse. | S_ISSUE on the pulse |
| S_INJ_RD | Reads one ROM word. | S_INJ_PUSH |
| S_INJ_PUSH | Pushes the ROM word. | S_INJ_RD for further words, S_BRWAIT after the last |

The transitions out of S_PUSH by class are:

| Class | Next state |
|---|---|
| JAL, or a plain instruction | S_ISSUE |
| Branch or JALR | S_BRWAIT |
| WFI | S_WFI |
| FENCE.I | S_FLUSH |
| ECALL, EBREAK or MRET | S_INJ_RD |

A soft reset request moves any state to S_ISSUE.

Top module: `fetch_seq`

## Requirements
- R1: Each pushed packet is 85 bits wide, with fields at these bit positions: [84] injected, [83] illegal, [82:79] class, [78:74] rd = word[11:7], [73:69] rs2 = word[24:20], [68:64] rs1 = word[19:15], [63:32] immediate, [31:0] PC of the instruction.
- R2: The immediate is sign-extended to 32 bits and follows the instruction format.
  - I format: OP-IMM, LOAD, JALR, SYSTEM and MISC-MEM.
  - S format: STORE.
  - B format: BRANCH.
  - U format: LUI and AUIPC.
  - J format: JAL.
  - R-type instructions and illegal words carry an immediate of 0.
- R3: The class codes are:
  - 0: OP, OP-IMM, LUI and AUIPC.
  - 1: load.
  - 2: store.
  - 3: branch.
  - 4: JAL.
  - 5: JALR.
  - 6: SYSTEM with funct3 not 0.
  - 7: FENCE.
  - 8: FENCE.I (funct3 = 1).
  - 9: WFI (0x10500073).
  - 10: ECALL (0x00000073).
  - 11: EBREAK (0x00100073).
  - 12: MRET (0x30200073).
  - 15: any other opcode. Such a word has the illegal bit set and is still pushed.
- R4: Only one memory read is outstanding at a time. After each ordinary instruction the next read is at PC+4, issued 3 cycles after the previous read when memory answers one cycle after the request.
- R5: JAL is pushed, and the next read goes to PC+immediate with no wait for execute.
- R6: A branch or JALR is pushed, and then no read is issued until br_done arrives. The next read is at br_pc.
- R7: WFI is not pushed.
  - Without an interrupt, the sequencer idles exactly WFI_MAX cycles and then reads PC+4.
  - An interrupt request cuts the wait short. It is then taken with PC+4 as its resume PC.
- R8: An interrupt request seen at an instruction boundary, an ECALL or an EBREAK each inject the entry sequence 0xFF010113, 0x00112023, 0x00512223, 0x00000013.
  - The packets carry the injected bit and a PC. That PC is the resume PC for an interrupt, or the PC of the trapping instruction.
  - The trapping instruction itself is not pushed.
  - After the sequence, the sequencer waits for br_done.
- R9: MRET is not pushed. It injects the exit sequence 0x00412283, 0x00012083, 0x01010113, 0x30200073, with the PC of the MRET, and then waits for br_done.
- R10: Injected packets are pushed exactly two cycles apart while the FIFO is not full.
- R11: FENCE.I raises flush_req and holds it until flush_done, with no reads meanwhile. The next read is then at PC+4.
- R12: A reset_req pulse in any state makes the next read go to RESET_VEC.
- R13: No packet is pushed while fifo_full is high. The pending packet is held and is delivered unchanged once space frees up.
- R14: An interrupt request is not accepted while an entry or exit sequence is in progress, nor while waiting for br_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_req | output | 1 | Instruction read request, one cycle |
| imem_addr | output | 32 | Read address (current PC) |
| imem_valid | input | 1 | Read data valid |
| imem_data | input | 32 | Returned instruction word |
| fifo_push | output | 1 | Push a packet into the instruction FIFO |
| fifo_pkt | output | 85 | Packet, layout as in R1 |
| fifo_full | input | 1 | FIFO cannot accept a packet |
| br_done | input | 1 | Execute has resolved a branch |
| br_pc | input | 32 | Resolved next PC |
| irq_req | input | 1 | Interrupt request level |
| flush_req | output | 1 | Instruction-cache flush request |
| flush_done | input | 1 | Flush complete |
| reset_req | input | 1 | Soft restart to the reset vector |

## Verification
The decoder is driven by a sweep of 48 hashed words. The opcode rotates through R, I, U (both kinds), load, store and two illegal patterns, while the remaining bits vary and take both signs. This separates each immediate format and exposes any misplaced register field. The branch terminating the sweep, forward and backward JALs, WFI both with and without an interrupt, FENCE.I with a delayed completion, ECALL, MRET, a held-full FIFO and a soft reset during a branch wait each exercise a different state transition. Each is told apart by the address and cycle of the next read, and by the count and spacing of the packets that follow.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [3:0] {
        C_ALU    = 4'd0,
        C_LOAD   = 4'd1,
        C_STORE  = 4'd2,
        C_BRANCH = 4'd3,
        C_JAL    = 4'd4,
        C_JALR   = 4'd5,
        C_SYS    = 4'd6,
        C_FENCE  = 4'd7,
        C_FENCEI = 4'd8,
        C_WFI    = 4'd9,
        C_ECALL  = 4'd10,
        C_EBREAK = 4'd11,
        C_MRET   = 4'd12,
        C_ILL    = 4'd15
    } icls_e;

    typedef enum logic [2:0] {
        F_NONE, F_I, F_S, F_B, F_U, F_J
    } ifmt_e;

    typedef struct packed {
        logic        inj;
        logic        ill;
        icls_e       cls;
        logic [4:0]  rd;
        logic [4:0]  rs2;
        logic [4:0]  rs1;
        logic [31:0] imm;
        logic [31:0] pc;
    } pkt_t;

    localparam int PKT_W = $bits(pkt_t);

    localparam logic [31:0] W_NOP    = 32'h0000_0013;
    localparam logic [31:0] W_ECALL  = 32'h0000_0073;
    localparam logic [31:0] W_EBREAK = 32'h0010_0073;
    localparam logic [31:0] W_WFI    = 32'h1050_0073;
    localparam logic [31:0] W_MRET   = 32'h3020_0073;

    // handler prologue: make stack room, save two registers
    function automatic logic [31:0] entry_word(input int i);
        unique case (i)
            0:       return 32'hFF01_0113;
            1:       return 32'h0011_2023;
            2:       return 32'h0051_2223;
            default: return W_NOP;
        endcase
    endfunction

    // handler epilogue: restore, release stack, return
    function automatic logic [31:0] exit_word(input int i, input int n);
        if (i == n - 1) return W_MRET;
        unique case (i)
            0:       return 32'h0041_2283;
            1:       return 32'h0001_2083;
            2:       return 32'h0101_0113;
            default: return W_NOP;
        endcase
    endfunction

endpackage

// File: rtl/fs_decode.sv
module fs_decode
    import fetch_pkg::*;
(
    input  logic [31:0] word,
    input  logic [31:0] pc,
    input  logic        inj,
    output pkt_t        pkt
);
    ifmt_e       fmt;
    icls_e       cls;
    logic        ill;
    logic [31:0] imm;

    always_comb begin
        fmt = F_NONE;
        cls = C_ILL;
        ill = 1'b0;
        unique case (word[6:0])
            7'b0110011: cls = C_ALU;
            7'b0010011: begin cls = C_ALU;    fmt = F_I; end
            7'b0110111: begin cls = C_ALU;    fmt = F_U; end
            7'b0010111: begin cls = C_ALU;    fmt = F_U; end
            7'b0000011: begin cls = C_LOAD;   fmt = F_I; end
            7'b0100011: begin cls = C_STORE;  fmt = F_S; end
            7'b1100011: begin cls = C_BRANCH; fmt = F_B; end
            7'b1101111: begin cls = C_JAL;    fmt = F_J; end
            7'b1100111: begin cls = C_JALR;   fmt = F_I; end
            7'b0001111: begin
                fmt = F_I;
                cls = (word[14:12] == 3'b001) ? C_FENCEI : C_FENCE;
            end
            7'b1110011: begin
                fmt = F_I;
                if (word == W_ECALL)            cls = C_ECALL;
                else if (word == W_EBREAK)      cls = C_EBREAK;
                else if (word == W_WFI)         cls = C_WFI;
                else if (word == W_MRET)        cls = C_MRET;
                else if (word[14:12] != 3'b000) cls = C_SYS;
                else begin
                    cls = C_ILL;
                    ill = 1'b1;
                    fmt = F_NONE;
                end
            end
            default: ill = 1'b1;
        endcase
    end

    always_comb begin
        unique case (fmt)
            F_I:     imm = {{20{word[31]}}, word[31:20]};
            F_S:     imm = {{20{word[31]}}, word[31:25], word[11:7]};
            F_B:     imm = {{19{word[31]}}, word[31], word[7], word[30:25], word[11:8], 1'b0};
            F_U:     imm = {word[31:12], 12'h000};
            F_J:     imm = {{11{word[31]}}, word[31], word[19:12], word[20], word[30:21], 1'b0};
            default: imm = 32'h0;
        endcase
    end

    always_comb begin
        pkt.inj = inj;
        pkt.ill = ill;
        pkt.cls = cls;
        pkt.rd  = word[11:7];
        pkt.rs2 = word[24:20];
        pkt.rs1 = word[19:15];
        pkt.imm = imm;
        pkt.pc  = pc;
    end

endmodule

// File: rtl/fs_rom.sv
module fs_rom
    import fetch_pkg::*;
#(
    parameter int SEQ_LEN = 4,
    parameter int IDX_W   = $clog2(SEQ_LEN)
) (
    input  logic             sel_exit,
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word
);
    logic [31:0] ent_tab [SEQ_LEN];
    logic [31:0] ext_tab [SEQ_LEN];

    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_tab
        assign ent_tab[g] = entry_word(g);
        assign ext_tab[g] = exit_word(g, SEQ_LEN);
    end

    assign word = sel_exit ? ext_tab[idx] : ent_tab[idx];

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000,
    parameter int          WFI_MAX   = 16,
    parameter int          SEQ_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             imem_req,
    output logic [31:0]      imem_addr,
    input  logic             imem_valid,
    input  logic [31:0]      imem_data,
    output logic             fifo_push,
    output logic [PKT_W-1:0] fifo_pkt,
    input  logic             fifo_full,
    input  logic             br_done,
    input  logic [31:0]      br_pc,
    input  logic             irq_req,
    output logic             flush_req,
    input  logic             flush_done,
    input  logic             reset_req
);
    localparam int CNT_W = (WFI_MAX > 1) ? $clog2(WFI_MAX) : 1;
    localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WFI_MAX - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SEQ_LEN - 1);

    typedef enum logic [3:0] {
        S_BOOT, S_ISSUE, S_WAIT, S_PUSH, S_BRWAIT,
        S_WFI, S_FLUSH, S_INJ_RD, S_INJ_PUSH
    } st_e;

    st_e              state, state_n;
    logic [31:0]      pc;
    logic [31:0]      ireg;
    logic [31:0]      inj_word;
    logic [31:0]      rom_word;
    logic [CNT_W-1:0] wcnt;
    logic [IDX_W-1:0] inj_idx;
    logic             inj_exit;
    logic [31:0]      dec_word;
    logic             dec_inj;
    pkt_t             dec_pkt;
    logic             pushable;
    logic             push_go;

    assign dec_inj  = (state == S_INJ_PUSH);
    assign dec_word = dec_inj ? inj_word : ireg;

    fs_decode u_dec (
        .word (dec_word),
        .pc   (pc),
        .inj  (dec_inj),
        .pkt  (dec_pkt)
    );

    fs_rom #(.SEQ_LEN(SEQ_LEN), .IDX_W(IDX_W)) u_rom (
        .sel_exit (inj_exit),
        .idx      (inj_idx),
        .word     (rom_word)
    );

    // trigger instructions are consumed by the sequencer itself
    always_comb begin
        unique case (dec_pkt.cls)
            C_WFI, C_FENCEI, C_ECALL, C_EBREAK, C_MRET: pushable = 1'b0;
            default:                                    pushable = 1'b1;
        endcase
    end

    assign push_go = !pushable || !fifo_full;

    // next-state logic
    always_comb begin
        state_n = state;
        if (reset_req) begin
            state_n = S_ISSUE;
        end else begin
            unique case (state)
                S_BOOT:  state_n = S_ISSUE;
                S_ISSUE: state_n = irq_req ? S_INJ_RD : S_WAIT;
                S_WAIT:  if (imem_valid) state_n = S_PUSH;
                S_PUSH: begin
                    if (push_go) begin
                        unique case (dec_pkt.cls)
                            C_BRANCH, C_JALR:         state_n = S_BRWAIT;
                            C_WFI:                    state_n = S_WFI;
                            C_FENCEI:                 state_n = S_FLUSH;
                            C_ECALL, C_EBREAK, C_MRET: state_n = S_INJ_RD;
                            default:                  state_n = S_ISSUE;
                        endcase
                    end
                end
                S_WFI:      if (irq_req || wcnt == CNT_LAST) state_n = S_ISSUE;
                S_FLUSH:    if (flush_done) state_n = S_ISSUE;
                S_BRWAIT:   if (br_done) state_n = S_ISSUE;
                S_INJ_RD:   state_n = S_INJ_PUSH;
                S_INJ_PUSH: begin
                    if (!fifo_full)
                        state_n = (inj_idx == IDX_LAST) ? S_BRWAIT : S_INJ_RD;
                end
                default:    state_n = S_ISSUE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= RESET_VEC;
            ireg     <= W_NOP;
            inj_word <= W_NOP;
            wcnt     <= '0;
            inj_idx  <= '0;
            inj_exit <= 1'b0;
        end else if (reset_req) begin
            pc <= RESET_VEC;
        end else begin
            unique case (state)
                S_ISSUE: begin
                    if (irq_req) begin
                        inj_idx  <= '0;
                        inj_exit <= 1'b0;
                    end
                end
                S_WAIT: if (imem_valid) ireg <= imem_data;
                S_PUSH: begin
                    if (push_go) begin
                        case (dec_pkt.cls)
                            C_JAL:             pc <= pc + dec_pkt.imm;
                            C_BRANCH, C_JALR,
                            C_FENCEI:          ;
                            C_WFI: begin
                                pc   <= pc + 32'd4;
                                wcnt <= '0;
                            end
                            C_ECALL, C_EBREAK: begin
                                inj_idx  <= '0;
                                inj_exit <= 1'b0;
                            end
                            C_MRET: begin
                                inj_idx  <= '0;
                                inj_exit <= 1'b1;
                            end
                            default:           pc <= pc + 32'd4;
                        endcase
                    end
                end
                S_WFI:      wcnt <= wcnt + 1'b1;
                S_FLUSH:    if (flush_done) pc <= pc + 32'd4;
                S_BRWAIT:   if (br_done) pc <= br_pc;
                S_INJ_RD:   inj_word <= rom_word;
                S_INJ_PUSH: if (!fifo_full && inj_idx != IDX_LAST) inj_idx <= inj_idx + 1'b1;
                default:    ;
            endcase
        end
    end

    // outputs
    always_comb begin
        imem_req  = (state == S_ISSUE) && !irq_req && !reset_req;
        imem_addr = pc;
        fifo_push = !reset_req && !fifo_full &&
                    (((state == S_PUSH) && pushable) || (state == S_INJ_PUSH));
        fifo_pkt  = dec_pkt;
        flush_req = (state == S_FLUSH);
    end

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000,
    parameter int          PKT_W     = 85
) (
    input logic             clk,
    input logic             rst_n,
    input logic             imem_req,
    input logic [31:0]      imem_addr,
    input logic             fifo_push,
    input logic [PKT_W-1:0] fifo_pkt,
    input logic             fifo_full,
    input logic             irq_req,
    input logic             flush_req,
    input logic             flush_done,
    input logic             reset_req
);
    // R13: full FIFO blocks every push
    p_no_push_full_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R4: a read is never requested on two consecutive cycles
    p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req |=> !imem_req);

    // R11: no read while a flush is requested
    p_flush_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !imem_req);

    // R11: flush request held until completion
    p_flush_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done && !reset_req) |=> flush_req);

    // R10: an injected push is followed by a cycle with no push
    p_inj_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_pkt[PKT_W-1]) |=> !fifo_push);

    // R12: the cycle after a soft reset request reads the reset vector
    p_reset_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !irq_req) |=> (reset_req || irq_req ||
                                     (imem_req && imem_addr == RESET_VEC)));

endmodule

bind fetch_seq fetch_seq_chk #(
    .RESET_VEC (RESET_VEC),
    .PKT_W     (fetch_pkg::PKT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_req   (imem_req),
    .imem_addr  (imem_addr),
    .fifo_push  (fifo_push),
    .fifo_pkt   (fifo_pkt),
    .fifo_full  (fifo_full),
    .irq_req    (irq_req),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .reset_req  (reset_req)
);

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
    localparam int PW = 85;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_req;
    logic [31:0]   imem_addr;
    logic          imem_valid = 1'b0;
    logic [31:0]   imem_data = 32'h0;
    logic          fifo_push;
    logic [PW-1:0] fifo_pkt;
    logic          fifo_full = 1'b0;
    logic          br_done = 1'b0;
    logic [31:0]   br_pc = 32'h0;
    logic          irq_req = 1'b0;
    logic          flush_req;
    logic          flush_done = 1'b0;
    logic          reset_req = 1'b0;

    always #10 clk = ~clk;

    fetch_seq u0 (
        .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_valid(imem_valid), .imem_data(imem_data), .fifo_push(fifo_push),
        .fifo_pkt(fifo_pkt), .fifo_full(fifo_full), .br_done(br_done), .br_pc(br_pc),
        .irq_req(irq_req), .flush_req(flush_req), .flush_done(flush_done),
        .reset_req(reset_req)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] mem [256];
    logic [31:0]   rq_addr [256];
    int            rq_cyc  [256];
    int            nrq = 0;
    logic [PW-1:0] pk      [256];
    int            pk_cyc  [256];
    int            npk = 0;
    logic          pend = 1'b0;
    logic [31:0]   pend_addr = 32'h0;

    localparam logic [31:0] NOP   = 32'h0000_0013;
    localparam logic [31:0] BEQ   = 32'h0000_0063;
    localparam logic [31:0] ADDI  = 32'h0012_8293;
    localparam logic [31:0] WFI   = 32'h1050_0073;
    localparam logic [31:0] FENCI = 32'h0000_100F;
    localparam logic [31:0] ECALL = 32'h0000_0073;
    localparam logic [31:0] MRET  = 32'h3020_0073;

    function automatic logic [31:0] ent_w(int i);
        logic [31:0] t [4] = '{32'hFF010113, 32'h00112023, 32'h00512223, 32'h00000013};
        return t[i];
    endfunction
    function automatic logic [31:0] ext_w(int i);
        logic [31:0] t [4] = '{32'h00412283, 32'h00012083, 32'h01010113, 32'h30200073};
        return t[i];
    endfunction

    function automatic logic [31:0] gen(int k);
        logic [31:0] h;
        logic [6:0]  op;
        h = 32'(k) * 32'h9E3779B1 ^ 32'h5A5A1234;
        case (k % 8)
            0: op = 7'b0110011;
            1: op = 7'b0010011;
            2: op = 7'b0110111;
            3: op = 7'b0010111;
            4: op = 7'b0000011;
            5: op = 7'b0100011;
            6: op = 7'b0001011;
            default: op = 7'b1111100;
        endcase
        return {h[31:7], op};
    endfunction

    // expected packet per R1, R2, R3
    function automatic logic [PW-1:0] exp_pkt(logic [31:0] w, logic [31:0] pc, logic inj);
        logic [3:0]  c;
        logic        il;
        logic [31:0] im;
        logic [31:0] ii, si, bi, ui, ji;
        ii = {{20{w[31]}}, w[31:20]};
        si = {{20{w[31]}}, w[31:25], w[11:7]};
        bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        ui = {w[31:12], 12'h0};
        ji = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        il = 1'b0; c = 4'd15; im = 32'h0;
        case (w[6:0])
            7'b0110011: c = 4'd0;
            7'b0010011: begin c = 4'd0; im = ii; end
            7'b0110111, 7'b0010111: begin c = 4'd0; im = ui; end
            7'b0000011: begin c = 4'd1; im = ii; end
            7'b0100011: begin c = 4'd2; im = si; end
            7'b1100011: begin c = 4'd3; im = bi; end
            7'b1101111: begin c = 4'd4; im = ji; end
            7'b1100111: begin c = 4'd5; im = ii; end
            7'b0001111: begin c = (w[14:12] == 3'd1) ? 4'd8 : 4'd7; im = ii; end
            7'b1110011: begin
                im = ii;
                if (w == ECALL) c = 4'd10;
                else if (w == 32'h00100073) c = 4'd11;
                else if (w == WFI) c = 4'd9;
                else if (w == MRET) c = 4'd12;
                else if (w[14:12] != 3'd0) c = 4'd6;
                else begin il = 1'b1; im = 32'h0; end
            end
            default: il = 1'b1;
        endcase
        return {inj, il, c, w[11:7], w[24:20], w[19:15], im, pc};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pk(int n, string tag);
        int t = 0;
        while (npk < n && t < 3000) begin tick(1); t++; end
        chk(npk >= n, tag, npk, n);
    endtask

    task automatic wait_rq(int n, string tag);
        int t = 0;
        while (nrq < n && t < 3000) begin tick(1); t++; end
        chk(nrq >= n, tag, nrq, n);
    endtask

    task automatic pulse_br(logic [31:0] a);
        @(negedge clk); br_done = 1'b1; br_pc = a;
        @(negedge clk); br_done = 1'b0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model and logging, all at the falling edge
    always @(negedge clk) begin
        if (pend) begin
            imem_valid <= 1'b1;
            imem_data  <= mem[pend_addr[9:2]];
            pend       <= 1'b0;
        end else begin
            imem_valid <= 1'b0;
        end
        if (rst_n && imem_req) begin
            pend      <= 1'b1;
            pend_addr <= imem_addr;
            rq_addr[nrq] <= imem_addr;
            rq_cyc[nrq]  <= cyc;
            nrq <= nrq + 1;
        end
        if (rst_n && fifo_push) begin
            pk[npk]     <= fifo_pkt;
            pk_cyc[npk] <= cyc;
            npk <= npk + 1;
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = NOP;
        for (int k = 0; k < 48; k++) mem[k] = gen(k);
        mem[48]  = BEQ;
        mem[64]  = 32'h0400_00EF;
        mem[80]  = 32'hFE1F_F06F;
        mem[72]  = WFI;
        mem[73]  = FENCI;
        mem[74]  = ECALL;
        mem[128] = MRET;
        mem[96]  = ADDI; mem[97] = ADDI; mem[98] = WFI;
        mem[99]  = ADDI; mem[100] = ADDI; mem[101] = ADDI;
        mem[102] = BEQ;

        // reset state
        tick(3);
        chk(!imem_req && !fifo_push && !flush_req, "R12 reset outputs idle",
            {imem_req, fifo_push, flush_req}, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 sweep
        wait_pk(49, "R4 sweep progress");
        for (int k = 0; k < 49; k++) begin
            chk(pk[k] == exp_pkt(mem[k], 32'(4 * k), 1'b0), "R1 R2 R3 sweep packet",
                pk[k], exp_pkt(mem[k], 32'(4 * k), 1'b0));
            chk(rq_addr[k] == 32'(4 * k), "R4 sequential address", rq_addr[k], 4 * k);
        end
        for (int k = 0; k < 48; k++)
            chk(rq_cyc[k + 1] - rq_cyc[k] == 3, "R4 read spacing", rq_cyc[k + 1] - rq_cyc[k], 3);
        tick(20);
        chk(nrq == 49, "R6 no read while branch unresolved", nrq, 49);

        // R5 R7: resolve to 0x100, JAL +64, JAL -32, WFI
        pulse_br(32'h100);
        wait_rq(53, "R7 fetch after WFI");
        chk(rq_addr[49] == 32'h100, "R6 read at br_pc", rq_addr[49], 32'h100);
        chk(rq_addr[50] == 32'h140, "R5 forward jump target", rq_addr[50], 32'h140);
        chk(rq_addr[51] == 32'h120, "R5 backward jump target", rq_addr[51], 32'h120);
        chk(rq_cyc[50] - rq_cyc[49] == 3, "R5 no wait on JAL", rq_cyc[50] - rq_cyc[49], 3);
        chk(rq_addr[52] == 32'h124, "R7 resume at PC+4", rq_addr[52], 32'h124);
        chk(rq_cyc[52] - rq_cyc[51] == 19, "R7 idle WFI_MAX cycles", rq_cyc[52] - rq_cyc[51], 19);
        chk(pk[49] == exp_pkt(mem[64], 32'h100, 1'b0), "R5 JAL packet", pk[49], exp_pkt(mem[64], 32'h100, 1'b0));
        chk(pk[50] == exp_pkt(mem[80], 32'h140, 1'b0), "R2 negative J immediate", pk[50], exp_pkt(mem[80], 32'h140, 1'b0));

        // R11 flush
        begin
            int t = 0;
            while (!flush_req && t < 100) begin tick(1); t++; end
        end
        chk(flush_req, "R11 flush requested", flush_req, 1);
        tick(10);
        chk(flush_req && nrq == 53, "R11 held, no reads", nrq, 53);
        chk(npk == 51, "R7 R11 WFI and FENCE.I not pushed", npk, 51);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        wait_rq(54, "R11 fetch after flush");
        chk(rq_addr[53] == 32'h128, "R11 resume at PC+4", rq_addr[53], 32'h128);

        // R8 ECALL entry injection, R10 rate
        wait_pk(55, "R8 entry sequence");
        for (int i = 0; i < 4; i++)
            chk(pk[51 + i] == exp_pkt(ent_w(i), 32'h128, 1'b1), "R8 ecall entry packet",
                pk[51 + i], exp_pkt(ent_w(i), 32'h128, 1'b1));
        for (int i = 0; i < 3; i++)
            chk(pk_cyc[52 + i] - pk_cyc[51 + i] == 2, "R10 injection spacing",
                pk_cyc[52 + i] - pk_cyc[51 + i], 2);
        tick(10);
        chk(nrq == 54 && npk == 55, "R8 waits for br_done after entry", nrq, 54);

        // R9 MRET exit injection
        pulse_br(32'h200);
        wait_pk(59, "R9 exit sequence");
        for (int i = 0; i < 4; i++)
            chk(pk[55 + i] == exp_pkt(ext_w(i), 32'h200, 1'b1), "R9 exit packet",
                pk[55 + i], exp_pkt(ext_w(i), 32'h200, 1'b1));
        for (int i = 0; i < 3; i++)
            chk(pk_cyc[56 + i] - pk_cyc[55 + i] == 2, "R10 exit spacing",
                pk_cyc[56 + i] - pk_cyc[55 + i], 2);
        tick(10);
        chk(nrq == 55, "R9 waits for br_done after exit", nrq, 55);

        // R7 R8 R14 interrupt during WFI
        pulse_br(32'h180);
        wait_rq(58, "R7 fetch of WFI");
        tick(5);
        irq_req = 1'b1;
        wait_pk(65, "R8 interrupt entry");
        chk(pk[59] == exp_pkt(ADDI, 32'h180, 1'b0), "R1 packet before WFI", pk[59], exp_pkt(ADDI, 32'h180, 1'b0));
        chk(pk[60] == exp_pkt(ADDI, 32'h184, 1'b0), "R1 packet before WFI", pk[60], exp_pkt(ADDI, 32'h184, 1'b0));
        for (int i = 0; i < 4; i++)
            chk(pk[61 + i] == exp_pkt(ent_w(i), 32'h18C, 1'b1), "R8 interrupt entry packet",
                pk[61 + i], exp_pkt(ent_w(i), 32'h18C, 1'b1));
        chk(pk_cyc[61] - rq_cyc[57] < 19, "R7 interrupt shortens WFI", pk_cyc[61] - rq_cyc[57], 19);
        tick(10);
        chk(npk == 65 && nrq == 58, "R14 no reentry while injecting or waiting", npk, 65);
        irq_req = 1'b0;

        // R13 full FIFO
        fifo_full = 1'b1;
        pulse_br(32'h18C);
        tick(10);
        chk(nrq == 59 && rq_addr[58] == 32'h18C, "R13 read issued, no more", nrq, 59);
        chk(npk == 65, "R13 no push while full", npk, 65);
        fifo_full = 1'b0;
        wait_pk(69, "R13 delivery after full");
        for (int i = 0; i < 3; i++)
            chk(pk[65 + i] == exp_pkt(ADDI, 32'(32'h18C + 4 * i), 1'b0), "R13 held packet delivered",
                pk[65 + i], exp_pkt(ADDI, 32'(32'h18C + 4 * i), 1'b0));
        chk(pk[68] == exp_pkt(BEQ, 32'h198, 1'b0), "R3 branch packet", pk[68], exp_pkt(BEQ, 32'h198, 1'b0));

        // R12 soft reset during branch wait
        tick(3);
        @(negedge clk); reset_req = 1'b1;
        @(negedge clk); reset_req = 1'b0;
        wait_rq(63, "R12 fetch after soft reset");
        chk(rq_addr[62] == 32'h0, "R12 read at reset vector", rq_addr[62], 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule